// File: doc/BRIEF.md
# Data Island Nibble Formatter

This block turns one complete data island packet into the 4-bit symbols that a TERC4 encoder sends on the three TMDS channels. The packet is presented in one cycle on a load strobe. It is made of a 32-bit header, whose top byte is the header ECC, and four 64-bit subpackets, each with its ECC byte in the top byte. The block then plays the packet out over 32 consecutive cycles. Each cycle it gives one nibble per channel, together with a valid flag.

Channel 0 carries four bits: a flag that marks every word except the first, one header bit per cycle, and the current levels of the two sync lines. Channel 1 gathers the even bits of all four subpackets and channel 2 gathers the odd bits, two subpacket bits per cycle per subpacket. The sync levels are taken from the inputs in the cycle in which they are sent, not at load time, so the packet follows the sync timing of the surrounding raster. The ECC bytes, the 10-bit TERC4 mapping, the preamble and the guard bands are produced elsewhere.

Top module: `island_nibble_fmt`

## Requirements
- R1: A load strobe seen at a rising edge while `busy_o` is low starts a packet. From that edge `busy_o` and `valid_o` are high for exactly 32 cycles, numbered 0 to 31, and then low.
- R2: Bit 3 of `ch0_o` is 0 on cycle 0 and 1 on cycles 1 to 31.
- R3: On cycle i, bit 2 of `ch0_o` equals header bit i, where header bit 0 is the LSB of `hdr_i`.
- R4: On every valid cycle, bits 1 and 0 of `ch0_o` equal `vsync_i` and `hsync_i` in that same cycle.
- R5: On cycle i, `ch1_o` is {S3[2i], S2[2i], S1[2i], S0[2i]} from MSB to LSB, where subpacket k is `sub_i[64k+63:64k]`.
- R6: On cycle i, `ch2_o` is {S3[2i+1], S2[2i+1], S1[2i+1], S0[2i+1]} from MSB to LSB.
- R7: A load strobe seen while `busy_o` is high is ignored. This holds on cycle 31 as well. The packet in flight and its cycle count do not change, and no second packet starts.
- R8: While `valid_o` is low, all three nibble outputs are zero.
- R9: After reset `busy_o` and `valid_o` are low.
- R10: The packet is captured at the accepting edge. Later changes on `hdr_i` and `sub_i` have no effect on the packet being sent.
- R11: An all-zero packet sent with hsync 0 and vsync 1 gives channel 0 nibble 0010 on cycle 0 and 1010 on every later cycle, with zero on channels 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Packet load strobe |
| hdr_i | input | 32 | Header; bits 31:24 are its ECC byte |
| sub_i | input | 256 | Four subpackets, subpacket k at bits 64k+63:64k |
| hsync_i | input | 1 | Live horizontal sync level |
| vsync_i | input | 1 | Live vertical sync level |
| busy_o | output | 1 | Packet in progress |
| valid_o | output | 1 | Nibbles on the channel outputs are valid |
| ch0_o | output | 4 | Channel 0 nibble {not-first, header bit, vsync, hsync} |
| ch1_o | output | 4 | Channel 1 nibble, even subpacket bits |
| ch2_o | output | 4 | Channel 2 nibble, odd subpacket bits |

## Verification
The all-zero packet under fixed syncs checks the framing flag and the sync positions with no data in the way. Walking a single one through the header and through each subpacket checks that each bit lands on one cycle and one lane only, and that even and odd bits are not swapped. It also checks that the subpacket order within a nibble is right. Pseudo-random packets, sent while the syncs toggle every cycle and the input bus is scrambled after load, check that the syncs are taken live and the payload is captured once. Strobes during a packet, including on cycle 31, check that they are ignored.

// File: rtl/island_fmt_pkg.sv
package island_fmt_pkg;
  localparam int unsigned NIB_W      = 4;
  localparam int unsigned WORDS_DEF  = 32;
  localparam int unsigned N_SUB_DEF  = 4;

  typedef struct packed {
    logic not_first;
    logic hdr_bit;
    logic vsync;
    logic hsync;
  } ch0_nib_t;

  function automatic ch0_nib_t make_ch0(input logic first, input logic hbit,
                                        input logic vs, input logic hs);
    ch0_nib_t n;
    n.not_first = ~first;
    n.hdr_bit   = hbit;
    n.vsync     = vs;
    n.hsync     = hs;
    return n;
  endfunction
endpackage

// File: rtl/island_seq.sv
module island_seq #(
  parameter int unsigned WORDS = 32,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             first_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;

  assign accept_o = load_i & ~busy_q;
  assign first_o  = busy_q & (idx_q == '0);
  assign last_o   = busy_q & (idx_q == LAST_IDX);
  assign busy_o   = busy_q;
  assign idx_o    = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q) begin
      if (idx_q == LAST_IDX) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !busy_o) |=> (busy_o && idx_o == '0));
  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && idx_o != LAST_IDX) |=> (busy_o && idx_o == $past(idx_o) + 1'b1));
  assert_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && idx_o == LAST_IDX) |=> !busy_o);
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && load_i && idx_o != LAST_IDX) |=> idx_o != '0);
endmodule

// File: rtl/island_pkt_store.sv
module island_pkt_store #(
  parameter int unsigned WORDS = 32,
  parameter int unsigned N_SUB = 4,
  localparam int unsigned HDR_W = WORDS,
  localparam int unsigned SUB_W = 2 * WORDS,
  localparam int unsigned ALL_W = N_SUB * SUB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             busy_i,
  input  logic [HDR_W-1:0] hdr_i,
  input  logic [ALL_W-1:0] sub_i,
  output logic [HDR_W-1:0] hdr_o,
  output logic [ALL_W-1:0] sub_o
);
  logic [HDR_W-1:0] hdr_q;
  logic [ALL_W-1:0] sub_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_q <= '0;
      sub_q <= '0;
    end else if (accept_i) begin
      hdr_q <= hdr_i;
      sub_q <= sub_i;
    end
  end

  assign hdr_o = hdr_q;
  assign sub_o = sub_q;

  assert_hold_hdr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !accept_i) |=> $stable(hdr_o));
  assert_hold_sub_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !accept_i) |=> $stable(sub_o));
endmodule

// File: rtl/island_lane_mux.sv
module island_lane_mux
  import island_fmt_pkg::*;
#(
  parameter int unsigned WORDS = 32,
  parameter int unsigned N_SUB = 4,
  localparam int unsigned IDX_W = $clog2(WORDS),
  localparam int unsigned HDR_W = WORDS,
  localparam int unsigned SUB_W = 2 * WORDS,
  localparam int unsigned ALL_W = N_SUB * SUB_W
) (
  input  logic             valid_i,
  input  logic             first_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [HDR_W-1:0] hdr_i,
  input  logic [ALL_W-1:0] sub_i,
  input  logic             hsync_i,
  input  logic             vsync_i,
  output logic [NIB_W-1:0] ch0_o,
  output logic [N_SUB-1:0] ch1_o,
  output logic [N_SUB-1:0] ch2_o
);
  logic [N_SUB-1:0] even_bits;
  logic [N_SUB-1:0] odd_bits;
  ch0_nib_t         c0;

  for (genvar k = 0; k < N_SUB; k++) begin : g_lane
    logic [SUB_W-1:0] sp;
    assign sp           = sub_i[k*SUB_W +: SUB_W];
    assign even_bits[k] = sp[{idx_i, 1'b0}];
    assign odd_bits[k]  = sp[{idx_i, 1'b1}];
  end

  always_comb begin
    c0 = make_ch0(first_i, hdr_i[idx_i], vsync_i, hsync_i);
    if (valid_i) begin
      ch0_o = c0;
      ch1_o = even_bits;
      ch2_o = odd_bits;
    end else begin
      ch0_o = '0;
      ch1_o = '0;
      ch2_o = '0;
    end
  end
endmodule

// File: rtl/island_nibble_fmt.sv
module island_nibble_fmt (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [31:0]  hdr_i,
  input  logic [255:0] sub_i,
  input  logic         hsync_i,
  input  logic         vsync_i,
  output logic         busy_o,
  output logic         valid_o,
  output logic [3:0]   ch0_o,
  output logic [3:0]   ch1_o,
  output logic [3:0]   ch2_o
);
  localparam int unsigned WORDS = island_fmt_pkg::WORDS_DEF;
  localparam int unsigned N_SUB = island_fmt_pkg::N_SUB_DEF;
  localparam int unsigned IDX_W = $clog2(WORDS);

  logic             accept_w;
  logic             busy_w;
  logic             first_w;
  logic             last_w;
  logic [IDX_W-1:0] idx_w;
  logic [31:0]      hdr_w;
  logic [255:0]     sub_w;

  island_seq #(.WORDS(WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .accept_o(accept_w),
    .busy_o(busy_w), .first_o(first_w), .last_o(last_w), .idx_o(idx_w)
  );

  island_pkt_store #(.WORDS(WORDS), .N_SUB(N_SUB)) u_store (
    .clk(clk), .rst_n(rst_n), .accept_i(accept_w), .busy_i(busy_w),
    .hdr_i(hdr_i), .sub_i(sub_i), .hdr_o(hdr_w), .sub_o(sub_w)
  );

  island_lane_mux #(.WORDS(WORDS), .N_SUB(N_SUB)) u_mux (
    .valid_i(busy_w), .first_i(first_w), .idx_i(idx_w),
    .hdr_i(hdr_w), .sub_i(sub_w), .hsync_i(hsync_i), .vsync_i(vsync_i),
    .ch0_o(ch0_o), .ch1_o(ch1_o), .ch2_o(ch2_o)
  );

  assign busy_o  = busy_w;
  assign valid_o = busy_w;

  assert_first_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !busy_o) |=> (ch0_o[3] == 1'b0));
  assert_later_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_w) |=> (ch0_o[3] == 1'b1));
  assert_live_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (ch0_o[1:0] == {vsync_i, hsync_i}));
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (ch0_o == 4'd0 && ch1_o == 4'd0 && ch2_o == 4'd0));
endmodule

// File: tb/island_nibble_fmt_bench.sv
module island_nibble_fmt_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_i = 1'b0;
  logic [31:0]  hdr_i = '0;
  logic [255:0] sub_i = '0;
  logic         hsync_i = 1'b0;
  logic         vsync_i = 1'b0;
  logic         busy_o, valid_o;
  logic [3:0]   ch0_o, ch1_o, ch2_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #2.5 clk = ~clk;

  island_nibble_fmt u_island_nibble_fmt (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .hdr_i(hdr_i), .sub_i(sub_i),
    .hsync_i(hsync_i), .vsync_i(vsync_i), .busy_o(busy_o), .valid_o(valid_o),
    .ch0_o(ch0_o), .ch1_o(ch1_o), .ch2_o(ch2_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  function automatic logic [3:0] exp_lane(input logic [255:0] s, input int i, input int odd);
    logic [3:0] r;
    for (int k = 0; k < 4; k++) r[k] = s[64*k + 2*i + odd];
    return r;
  endfunction

  // sync_mode: 0 fixed hs=0 vs=1, 1 toggling per cycle
  // strobe_mode: 0 none, 1 strobe mid-packet and on cycle 31
  task automatic send(input logic [31:0] h, input logic [255:0] s,
                      input int sync_mode, input int strobe_mode, input string tag);
    @(negedge clk);
    hdr_i = h; sub_i = s; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    hdr_i = ~h; sub_i = {s[127:0], ~s[255:128]};   // R10: scrambled bus after load
    for (int i = 0; i < 32; i++) begin
      if (sync_mode == 0) begin hsync_i = 1'b0; vsync_i = 1'b1; end
      else begin hsync_i = i[0]; vsync_i = i[1] ^ lfsr[i]; end
      load_i = (strobe_mode == 1) && (i == 10 || i == 31);   // R7
      #1;
      chk(valid_o === 1'b1 && busy_o === 1'b1, "R1 valid", {valid_o, busy_o}, 3);
      chk(ch0_o[3] === (i != 0), "R2 first flag", ch0_o[3], (i != 0));
      chk(ch0_o[2] === h[i], "R3 header bit", ch0_o[2], h[i]);
      chk(ch0_o[1:0] === {vsync_i, hsync_i}, "R4 live sync", ch0_o[1:0], {vsync_i, hsync_i});
      chk(ch1_o === exp_lane(s, i, 0), {"R5 even lane ", tag}, ch1_o, exp_lane(s, i, 0));
      chk(ch2_o === exp_lane(s, i, 1), {"R6 odd lane ", tag}, ch2_o, exp_lane(s, i, 1));
      @(negedge clk);
    end
    load_i = 1'b0;
    #1;
    chk(valid_o === 1'b0 && busy_o === 1'b0, "R1 end after 32 / R7 no restart", {valid_o, busy_o}, 0);
    chk(ch0_o === 0 && ch1_o === 0 && ch2_o === 0, "R8 idle zero", {ch0_o, ch1_o, ch2_o}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    logic [255:0] s;
    logic [31:0]  h;
    repeat (3) @(negedge clk);
    #1;
    chk(busy_o === 1'b0 && valid_o === 1'b0, "R9 reset state", {busy_o, valid_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(ch0_o === 0 && ch1_o === 0 && ch2_o === 0, "R8 idle after reset", {ch0_o, ch1_o, ch2_o}, 0);

    // R11: null packet, hs=0 vs=1 -> 0010 then 1010, zero data lanes
    send(32'h0, 256'h0, 0, 0, "R11 null");

    // walking one through header
    for (int b = 0; b < 32; b += 3) send(32'h1 << b, 256'h0, 1, 0, "hdr walk");
    // walking one through each subpacket, even and odd positions
    for (int b = 0; b < 256; b += 7) begin
      s = '0; s[b] = 1'b1;
      send(32'h0, s, 1, 0, "sub walk");
    end
    // pseudo-random packets with strobes while busy
    for (int p = 0; p < 12; p++) begin
      for (int w = 0; w < 8; w++) begin lfsr = next_rand(lfsr); s[32*w +: 32] = lfsr; end
      lfsr = next_rand(lfsr); h = lfsr;
      send(h, s, 1, p % 2, "random");
    end
    // back-to-back: a packet right after one that ended
    send(32'hE40D_0282, {192'h0, 64'h7100_0000_0000_402F}, 0, 1, "back to back");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule